// File: doc/BRIEF.md
# Coarse/Fine Attack-Hold Note Sequencer

This block drives one actuator note through two phases. A restart strobe opens the attack phase. The attack output stays high for a delay that is set by three register values: a prescaler code, a coarse count and a fine count. When the delay runs out, the block moves the note into its hold phase. The hold output is then either a steady high level or a pulse-width-modulated waveform, and a mode flag chooses between them.

The delay is measured in ticks of a selectable clock divider. It is split into whole wraps of an 8-bit tick counter, 256 ticks each, followed by a fine remainder. A coarse count of zero skips the wrap stage and starts the fine stage at once. A repeat mode restarts the sequence every time it completes and toggles the attack output on each pass, which gives a free-running waveform for bench work. A note-off strobe stops the hold output and holds it low.

The PWM generator runs from its own duty and period registers. New values are staged on a load strobe and take effect only at the start of a period.

Top module: `note_phase_seq`

## Requirements
- R1: After reset, `phase_o` reads 0 (idle), and `attack_o`, `hold_o` and `state_o` are all 0. `phase_o` uses the codes 0 for idle, 1 for the coarse stage and 2 for the fine stage, and never shows 3.
- R2: One cycle after a `start_i` strobe, `attack_o` and `state_o[0]` are 1. `phase_o` is 1 if `coarse_i` is non-zero and 2 if it is zero.
- R3: With repeat off, `attack_o` falls exactly D*(C*256+F+1) clock cycles after the edge that sampled `start_i`. Here D is the divider, C is `coarse_i` and F is `fine_i`.
- R4: With C>0, `phase_o` changes from 1 to 2 exactly D*C*256 cycles after the start edge. The coarse stage only ever exits to the fine stage or to a new start.
- R5: With repeat off, the end of the fine stage clears `attack_o` and returns `phase_o` to 0. If `mode_i[1]` (PWM select) is 0, `hold_o` then stays at a steady 1.
- R6: If `mode_i[1]` is 1 at the end of the fine stage, `hold_o` follows the PWM waveform. Its counter runs from 0 up to the period value P, and the output is high while the count is below the duty value U. Over any P+1 consecutive cycles, `hold_o` is high for min(U, P+1) cycles.
- R7: `prescale_i` codes 1, 2, 3, 4 and 5 select dividers of 1, 8, 64, 256 and 1024. Codes 0, 6 and 7 stop the ticks, so the phase and `attack_o` stay frozen.
- R8: A `note_off_i` strobe drives `hold_o` low and stops the PWM. `hold_o` then stays low until a later end of the fine stage.
- R9: With `mode_i[0]` (repeat) set, the end of the fine stage restarts the sequence, inverts `attack_o` and runs the PWM on `hold_o`. With C=0 and divider 1, `attack_o` therefore toggles every F+1 cycles.
- R10: A `pwm_load_i` strobe captures `duty_i` and `freq_i`. The captured values replace the active ones only on the cycle in which the PWM counter wraps to 0.
- R11: `state_o[0]` mirrors the attack output. `state_o[1]` is 1 while the hold output is engaged, either as a steady level or as PWM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Restart strobe that begins the attack phase |
| note_off_i | input | 1 | Strobe that releases the hold output |
| coarse_i | input | 8 | Number of full 256-tick wraps |
| fine_i | input | 8 | Fine compare value |
| prescale_i | input | 3 | Tick divider code |
| mode_i | input | 2 | Bit 0 selects repeat, bit 1 selects PWM hold |
| duty_i | input | 8 | PWM duty value to stage |
| freq_i | input | 8 | PWM period top value to stage |
| pwm_load_i | input | 1 | Strobe that stages the duty and period values |
| attack_o | output | 1 | Attack output |
| hold_o | output | 1 | Hold output, steady or PWM |
| phase_o | output | 2 | Current stage: 0 idle, 1 coarse, 2 fine |
| state_o | output | 2 | Bit 0 attack, bit 1 hold engaged |

## Verification
The bench sweeps coarse counts from 0 to 2 against fine values that include 0 and 255, and it covers every valid divider code. The delay it measures must match D*(C*256+F+1) to the cycle. A design with an off-by-one in the compare, or one that failed to skip the coarse stage on a zero count, would end the attack early or late. It probes the cycle of the coarse-to-fine handover and the frozen state under an invalid divider code; a tick leaking through there would let the phase advance. It also checks the attack toggle cadence in repeat mode, where a missing inversion would leave the attack pin stuck high. Finally, it counts PWM high cycles per period for zero duty, for duty equal to the period and for duty above the period, and confirms that the hold output stays silent after note-off. A wrong compare direction would shift the count by one, and a missing stop would keep the output pulsing.

// File: rtl/nps_pkg.sv
package nps_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_COARSE = 2'd1,
        PH_FINE   = 2'd2
    } phase_e;

    localparam int MODE_REPEAT_BIT = 0;
    localparam int MODE_PWM_BIT    = 1;

endpackage

// File: rtl/nps_tick_div.sv
// Tick divider: the code selects a power-of-two divide ratio.
module nps_tick_div #(
    parameter int CODE_W  = 3,
    parameter int MAX_LG2 = 10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clear_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              tick_o
);
    localparam int CNT_W = MAX_LG2;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_t;

    div_t             d, q;
    logic             valid;
    int unsigned      lg;
    logic [CNT_W-1:0] lim;

    always_comb begin
        valid = 1'b1;
        lg    = 0;
        case (code_i)
            CODE_W'(1): lg = 0;
            CODE_W'(2): lg = 3;
            CODE_W'(3): lg = 6;
            CODE_W'(4): lg = 8;
            CODE_W'(5): lg = MAX_LG2;
            default: begin
                valid = 1'b0;
                lg    = 0;
            end
        endcase
        lim    = CNT_W'((32'd1 << lg) - 32'd1);
        tick_o = valid && (q.cnt == lim);

        d = q;
        if (clear_i) begin
            d.cnt = '0;
        end else if (valid) begin
            d.cnt = tick_o ? '0 : q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end
endmodule

// File: rtl/nps_phase_ctl.sv
// Attack/hold phase controller: coarse wraps, fine remainder, end-of-phase actions.
module nps_phase_ctl
    import nps_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         tick_i,
    input  logic         start_i,
    input  logic         note_off_i,
    input  logic [W-1:0] coarse_i,
    input  logic [W-1:0] fine_i,
    input  logic [1:0]   mode_i,
    output phase_e       phase_o,
    output logic         attack_o,
    output logic         hold_static_o,
    output logic         pwm_run_o
);
    localparam logic [W:0] ONE_X = (W+1)'(1);

    typedef struct packed {
        phase_e       phase;
        logic [W-1:0] tcnt;
        logic [W-1:0] top;
        logic [W-1:0] ccnt;
        logic         attack;
        logic         hold_st;
        logic         pwm_run;
    } ctl_t;

    ctl_t d, q;
    logic match;
    logic coarse_nz;

    always_comb begin
        d         = q;
        coarse_nz = (coarse_i != '0);
        match     = tick_i && (q.phase != PH_IDLE) && (q.tcnt == q.top);

        if (tick_i && q.phase != PH_IDLE) begin
            d.tcnt = match ? '0 : q.tcnt + W'(1);
        end

        if (match) begin
            case (q.phase)
                PH_COARSE: begin
                    d.ccnt = q.ccnt + W'(1);
                    if (({1'b0, q.ccnt} + ONE_X) >= {1'b0, coarse_i}) begin
                        d.phase = PH_FINE;
                        d.top   = fine_i;
                    end
                end
                PH_FINE: begin
                    if (mode_i[MODE_REPEAT_BIT]) begin
                        d.phase   = coarse_nz ? PH_COARSE : PH_FINE;
                        d.top     = coarse_nz ? '1 : fine_i;
                        d.tcnt    = '0;
                        d.ccnt    = '0;
                        d.attack  = !q.attack;
                        d.pwm_run = 1'b1;
                        d.hold_st = 1'b0;
                    end else begin
                        d.attack = 1'b0;
                        d.phase  = PH_IDLE;
                        if (mode_i[MODE_PWM_BIT]) begin
                            d.pwm_run = 1'b1;
                            d.hold_st = 1'b0;
                        end else begin
                            d.pwm_run = 1'b0;
                            d.hold_st = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end

        if (start_i) begin
            d.phase  = coarse_nz ? PH_COARSE : PH_FINE;
            d.top    = coarse_nz ? '1 : fine_i;
            d.tcnt   = '0;
            d.ccnt   = '0;
            d.attack = 1'b1;
        end

        if (note_off_i) begin
            d.pwm_run = 1'b0;
            d.hold_st = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q       <= '0;
            q.phase <= PH_IDLE;
        end else begin
            q <= d;
        end
    end

    assign phase_o       = q.phase;
    assign attack_o      = q.attack;
    assign hold_static_o = q.hold_st;
    assign pwm_run_o     = q.pwm_run;
endmodule

// File: rtl/nps_pwm_gen.sv
// PWM generator with staged duty/period that take effect at counter wrap.
module nps_pwm_gen #(
    parameter int           W        = 8,
    parameter logic [W-1:0] RST_DUTY = W'(127),
    parameter logic [W-1:0] RST_FREQ = W'(254)
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] duty_i,
    input  logic [W-1:0] freq_i,
    output logic         level_o,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] duty_o,
    output logic [W-1:0] freq_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] duty;
        logic [W-1:0] freq;
        logic         pend;
        logic [W-1:0] duty_stg;
        logic [W-1:0] freq_stg;
    } pwm_t;

    pwm_t d, q;
    logic wrap;

    always_comb begin
        d    = q;
        wrap = (q.cnt >= q.freq);
        d.cnt = wrap ? '0 : q.cnt + W'(1);
        if (wrap && q.pend) begin
            d.duty = q.duty_stg;
            d.freq = q.freq_stg;
            d.pend = 1'b0;
        end
        if (load_i) begin
            d.pend     = 1'b1;
            d.duty_stg = duty_i;
            d.freq_stg = freq_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q      <= '0;
            q.duty <= RST_DUTY;
            q.freq <= RST_FREQ;
        end else begin
            q <= d;
        end
    end

    assign level_o = (q.cnt < q.duty);
    assign cnt_o   = q.cnt;
    assign duty_o  = q.duty;
    assign freq_o  = q.freq;
endmodule

// File: rtl/note_phase_seq.sv
module note_phase_seq
    import nps_pkg::*;
#(
    parameter int W       = 8,
    parameter int CODE_W  = 3,
    parameter int MAX_LG2 = 10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              note_off_i,
    input  logic [W-1:0]      coarse_i,
    input  logic [W-1:0]      fine_i,
    input  logic [CODE_W-1:0] prescale_i,
    input  logic [1:0]        mode_i,
    input  logic [W-1:0]      duty_i,
    input  logic [W-1:0]      freq_i,
    input  logic              pwm_load_i,
    output logic              attack_o,
    output logic              hold_o,
    output logic [1:0]        phase_o,
    output logic [1:0]        state_o
);
    logic         tick;
    phase_e       phase;
    logic         hold_st;
    logic         pwm_run;
    logic         pwm_level;
    logic [W-1:0] pwm_cnt;
    logic [W-1:0] pwm_duty;
    logic [W-1:0] pwm_freq;

    nps_tick_div #(.CODE_W(CODE_W), .MAX_LG2(MAX_LG2)) div_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (start_i),
        .code_i  (prescale_i),
        .tick_o  (tick)
    );

    nps_phase_ctl #(.W(W)) ctl_i (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .tick_i        (tick),
        .start_i       (start_i),
        .note_off_i    (note_off_i),
        .coarse_i      (coarse_i),
        .fine_i        (fine_i),
        .mode_i        (mode_i),
        .phase_o       (phase),
        .attack_o      (attack_o),
        .hold_static_o (hold_st),
        .pwm_run_o     (pwm_run)
    );

    nps_pwm_gen #(.W(W)) pwm_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (pwm_load_i),
        .duty_i  (duty_i),
        .freq_i  (freq_i),
        .level_o (pwm_level),
        .cnt_o   (pwm_cnt),
        .duty_o  (pwm_duty),
        .freq_o  (pwm_freq)
    );

    assign phase_o = phase;
    assign hold_o  = pwm_run ? pwm_level : hold_st;
    assign state_o = {pwm_run | hold_st, attack_o};
endmodule

// File: rtl/nps_seq_checker.sv
module nps_seq_checker #(
    parameter int W      = 8,
    parameter int CODE_W = 3
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              start_i,
    input logic              note_off_i,
    input logic [CODE_W-1:0] prescale_i,
    input logic              attack_o,
    input logic              hold_o,
    input logic [1:0]        phase_o,
    input logic [1:0]        state_o,
    input logic [W-1:0]      pwm_cnt,
    input logic [W-1:0]      pwm_duty,
    input logic [W-1:0]      pwm_freq
);
    logic code_ok;
    assign code_ok = (prescale_i >= CODE_W'(1)) && (prescale_i <= CODE_W'(5));

    assert_phase_legal_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        phase_o != 2'd3);

    assert_start_attack_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> (attack_o && state_o[0] && phase_o != 2'd0));

    assert_coarse_exit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_o == 2'd1) |=> (phase_o != 2'd0));

    assert_end_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_o == 2'd0 && $past(phase_o) == 2'd2 && !$past(note_off_i) && !$past(start_i))
            |-> (!attack_o && state_o[1]));

    assert_frozen_code_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!code_ok && !start_i) |=> $stable(phase_o));

    assert_note_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        note_off_i |=> (!hold_o && !state_o[1]));

    assert_load_at_wrap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!$stable(pwm_duty) || !$stable(pwm_freq)) |-> ($past(pwm_cnt) >= $past(pwm_freq)));
endmodule

bind note_phase_seq nps_seq_checker #(.W(W), .CODE_W(CODE_W)) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .note_off_i (note_off_i),
    .prescale_i (prescale_i),
    .attack_o   (attack_o),
    .hold_o     (hold_o),
    .phase_o    (phase_o),
    .state_o    (state_o),
    .pwm_cnt    (pwm_cnt),
    .pwm_duty   (pwm_duty),
    .pwm_freq   (pwm_freq)
);

// File: tb/note_phase_seq_tb_top.sv
`timescale 1ns/1ps
module note_phase_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       note_off = 1'b0;
    logic [7:0] coarse = '0;
    logic [7:0] fine = '0;
    logic [2:0] presc = 3'd1;
    logic [1:0] mode = '0;
    logic [7:0] duty = '0;
    logic [7:0] freq = '0;
    logic       pwm_load = 1'b0;
    logic       attack_o;
    logic       hold_o;
    logic [1:0] phase_o;
    logic [1:0] state_o;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 0;

    always #2.5 clk = ~clk;

    note_phase_seq dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .start_i    (start),
        .note_off_i (note_off),
        .coarse_i   (coarse),
        .fine_i     (fine),
        .prescale_i (presc),
        .mode_i     (mode),
        .duty_i     (duty),
        .freq_i     (freq),
        .pwm_load_i (pwm_load),
        .attack_o   (attack_o),
        .hold_o     (hold_o),
        .phase_o    (phase_o),
        .state_o    (state_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    function automatic int div_of(input int code);
        case (code)
            1: return 1;
            2: return 8;
            3: return 64;
            4: return 256;
            5: return 1024;
            default: return 0;
        endcase
    endfunction

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic pulse_note_off();
        @(negedge clk); note_off = 1'b1;
        @(negedge clk); note_off = 1'b0;
    endtask

    task automatic run_note(input int c, input int f, input int code, input int md);
        int d;
        int k;
        int exp_end;
        d = div_of(code);
        exp_end = d * (c * 256 + f + 1);
        @(negedge clk);
        coarse = 8'(c); fine = 8'(f); presc = 3'(code); mode = 2'(md);
        pulse_start();
        chk("R2 attack after start", int'(attack_o), 1);
        chk("R2 phase after start", int'(phase_o), (c > 0) ? 1 : 2);
        chk("R11 state bit0 follows attack", int'(state_o[0]), 1);
        k = 0;
        while (attack_o && k < exp_end + 10) begin
            @(negedge clk);
            k++;
            if (c > 0 && k == d * c * 256 - 1) chk("R4 still coarse before handover", int'(phase_o), 1);
            if (c > 0 && k == d * c * 256)     chk("R4 fine at handover", int'(phase_o), 2);
        end
        chk("R3 cycles from start to attack end", k, exp_end);
        chk("R5 idle after end", int'(phase_o), 0);
        if (md == 0) begin
            chk("R5 static hold high", int'(hold_o), 1);
            chk("R11 state after end", int'(state_o), 2);
        end
    endtask

    task automatic pwm_window(input int u, input int p);
        int highs;
        @(negedge clk);
        duty = 8'(u); freq = 8'(p); pwm_load = 1'b1;
        @(negedge clk);
        pwm_load = 1'b0;
        repeat (520) @(negedge clk);
        highs = 0;
        for (int i = 0; i <= p; i++) begin
            @(negedge clk);
            if (hold_o) highs++;
        end
        chk("R6 R10 pwm highs per period", highs, (u < p + 1) ? u : p + 1);
        chk("R11 state bit1 with pwm", int'(state_o[1]), 1);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R3 watchdog: actual=expired expected=finished");
            report();
        end
    end

    initial begin
        int fvals[4];
        int highs;
        fvals = '{0, 1, 7, 255};
        repeat (3) @(negedge clk);
        chk("R1 reset phase", int'(phase_o), 0);
        chk("R1 reset attack", int'(attack_o), 0);
        chk("R1 reset hold", int'(hold_o), 0);
        chk("R1 reset state", int'(state_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle after release", int'(phase_o), 0);

        // Sweep of coarse and fine values at divider 1
        for (int c = 0; c < 3; c++) begin
            for (int i = 0; i < 4; i++) begin
                run_note(c, fvals[i], 1, 0);
            end
        end
        // Every valid divider code (R7)
        run_note(0, 0, 2, 0);
        run_note(0, 3, 2, 0);
        run_note(1, 2, 2, 0);
        run_note(0, 2, 3, 0);
        run_note(0, 1, 4, 0);
        run_note(0, 0, 5, 0);

        // Invalid divider code freezes the phase (R7)
        @(negedge clk);
        coarse = 8'd0; fine = 8'd2; presc = 3'd0; mode = 2'd0;
        pulse_start();
        repeat (300) @(negedge clk);
        chk("R7 code 0 keeps attack", int'(attack_o), 1);
        chk("R7 code 0 keeps phase", int'(phase_o), 2);
        presc = 3'd7;
        repeat (100) @(negedge clk);
        chk("R7 code 7 keeps phase", int'(phase_o), 2);
        presc = 3'd1;
        repeat (10) @(negedge clk);
        chk("R7 resumes with valid code", int'(attack_o), 0);

        pulse_note_off();
        chk("R8 hold low after note off", int'(hold_o), 0);

        // Repeat mode: attack toggles every F+1 cycles (R9)
        @(negedge clk);
        coarse = 8'd0; fine = 8'd3; presc = 3'd1; mode = 2'd1;
        pulse_start();
        for (int k = 1; k <= 16; k++) begin
            @(negedge clk);
            chk("R9 repeat attack toggle", int'(attack_o), ((k / 4) % 2 == 0) ? 1 : 0);
        end
        chk("R9 repeat stays in fine", int'(phase_o), 2);
        mode = 2'd0;
        repeat (4) @(negedge clk);
        chk("R5 repeat off ends at idle", int'(phase_o), 0);
        chk("R5 repeat off attack low", int'(attack_o), 0);
        chk("R5 repeat off static hold", int'(hold_o), 1);

        // PWM hold (R6, R10)
        run_note(0, 0, 1, 2);
        pwm_window(3, 9);
        pwm_window(0, 9);
        pwm_window(12, 9);
        pwm_window(5, 5);
        pwm_window(100, 200);

        // Note off silences PWM (R8)
        pulse_note_off();
        highs = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (hold_o) highs++;
        end
        chk("R8 no pwm pulses after note off", highs, 0);
        chk("R8 R11 state after note off", int'(state_o), 0);

        report();
    end
endmodule